// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block decides, for a five-stage load/store pipeline, where each operand should come from when a value that an instruction needs has been computed but not yet written to the register file. It compares the register numbers that the execute-stage instruction reads against the destination numbers held in the two pipeline registers behind it. From that comparison it produces a 2-bit select for each of the two ALU input multiplexers. When both later stages will write the wanted register, the more recent result is chosen.

A second, narrower path serves a branch comparator placed in the decode stage. When decode holds a branch, each of its two source numbers is compared with the destination held in the execute/memory register. One select bit per compare input tells the comparator to take that stage's result in place of the register file value.

The unit is purely combinational. Its selects follow its inputs in the same cycle. The datapath multiplexers, the register file and any stall generation are built elsewhere.

Top module: `opfwd_unit`

## Requirements
- R1: `alu_sel_a` is 2'b10 whenever `xm_wr_en` is 1, `xm_dst` is not 0 and `xm_dst` equals `ex_src_a`.
- R2: `alu_sel_b` is 2'b10 whenever `xm_wr_en` is 1, `xm_dst` is not 0 and `xm_dst` equals `ex_src_b`.
- R3: An ALU select is 2'b01 when `mw_wr_en` is 1, `mw_dst` is not 0 and `mw_dst` equals that operand's source, but only when R1 or R2 does not already select 2'b10 for that operand. If the execute/memory stage matches the number but is not writing, the memory/writeback result is used.
- R4: Register number 0 is never forwarded. A destination of 0 gives neither 2'b10 nor 2'b01 on an ALU select and gives no compare forward, even when it matches and the write enable is set.
- R5: With no qualifying match, an ALU select is 2'b00, which picks the register file value. The value 2'b11 never appears.
- R6: `cmp_sel_a` is 1 when `id_is_branch` is 1, `xm_dst` is not 0 and `xm_dst` equals `id_src_a`. The write enable and the memory/writeback register play no part in this test.
- R7: `cmp_sel_b` is 1 under the same test applied to `id_src_b`.
- R8: Both compare selects are 0 whenever `id_is_branch` is 0.
- R9: The two ALU operands are resolved independently. One may take the execute/memory result while the other takes the memory/writeback result in the same cycle.
- R10: Every output follows its inputs combinationally, in the same cycle as an input change, with no clock or stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| xm_wr_en | input | 1 | Execute/memory register will write the register file |
| xm_dst | input | 5 | Execute/memory destination register number |
| mw_wr_en | input | 1 | Memory/writeback register will write the register file |
| mw_dst | input | 5 | Memory/writeback destination register number |
| ex_src_a | input | 5 | First source register number of the execute-stage instruction |
| ex_src_b | input | 5 | Second source register number of the execute-stage instruction |
| id_is_branch | input | 1 | Decode stage holds a branch |
| id_src_a | input | 5 | First source register number in decode |
| id_src_b | input | 5 | Second source register number in decode |
| alu_sel_a | output | 2 | ALU input A select: 00 register file, 01 memory/writeback, 10 execute/memory |
| alu_sel_b | output | 2 | ALU input B select, same encoding |
| cmp_sel_a | output | 1 | Branch compare input A takes the execute/memory result |
| cmp_sel_b | output | 1 | Branch compare input B takes the execute/memory result |

## Verification
The unit holds no state, so any fault in its comparison or priority logic shows on the select outputs in the same cycle as the offending input pattern. Nothing carries a wrong value forward to later cycles. The cases most likely to expose a fault are both producers naming the same register, a matching producer whose write enable is low, and register 0. A sweep over every destination number catches a comparator that drops or sticks a bit. A mistake here would feed a stale or wrong operand to the ALU in that same cycle.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;

   // Encoding seen by the ALU operand multiplexer
   typedef enum logic [1:0] {
      FWD_REGFILE = 2'b00,
      FWD_OLDER   = 2'b01,
      FWD_YOUNGER = 2'b10
   } alu_fwd_e;

   localparam int unsigned ALU_SRC_N = 2;
   localparam int unsigned CMP_SRC_N = 2;

endpackage

// File: rtl/opfwd_match.sv
// One producer/consumer comparison: a hit means the producer's result
// may stand in for the register file value of this source.
module opfwd_match #(
   parameter int unsigned REG_W     = 5,
   parameter bit          ZERO_SINK = 1'b1
) (
   input  logic             en,
   input  logic [REG_W-1:0] dst,
   input  logic [REG_W-1:0] src,
   output logic             hit
);

   logic same;
   assign same = (dst == src);

   generate
      if (ZERO_SINK) begin : g_zero_sink
         logic dst_live;
         assign dst_live = |dst;
         assign hit = en & dst_live & same;
      end else begin : g_plain
         assign hit = en & same;
      end
   endgenerate

endmodule

// File: rtl/opfwd_alu_pick.sv
// Priority pick for one ALU operand: the younger producer beats the older.
module opfwd_alu_pick
   import opfwd_pkg::*;
(
   input  logic     young_hit,
   input  logic     old_hit,
   output alu_fwd_e sel
);

   always_comb begin
      if (young_hit)
         sel = FWD_YOUNGER;
      else if (old_hit)
         sel = FWD_OLDER;
      else
         sel = FWD_REGFILE;
   end

   always_comb begin
      assert_sel_legal_R5 : assert (sel != alu_fwd_e'(2'b11));
      if (old_hit && !young_hit)
         assert_older_taken_R3 : assert (sel == FWD_OLDER);
   end

endmodule

// File: rtl/opfwd_unit.sv
module opfwd_unit
   import opfwd_pkg::*;
#(
   parameter int unsigned REG_W     = 5,
   parameter bit          ZERO_SINK = 1'b1
) (
   input  logic             xm_wr_en,
   input  logic [REG_W-1:0] xm_dst,
   input  logic             mw_wr_en,
   input  logic [REG_W-1:0] mw_dst,
   input  logic [REG_W-1:0] ex_src_a,
   input  logic [REG_W-1:0] ex_src_b,
   input  logic             id_is_branch,
   input  logic [REG_W-1:0] id_src_a,
   input  logic [REG_W-1:0] id_src_b,
   output logic [1:0]       alu_sel_a,
   output logic [1:0]       alu_sel_b,
   output logic             cmp_sel_a,
   output logic             cmp_sel_b
);

   localparam int unsigned REG_N = 1 << REG_W;

   generate
      if (REG_W < 1 || REG_W > 8) begin : g_bad_width
         $error("opfwd_unit: REG_W must lie in 1..8");
      end
      if (REG_N < 2) begin : g_bad_count
         $error("opfwd_unit: need at least two registers");
      end
   endgenerate

   logic [REG_W-1:0] ex_src [ALU_SRC_N];
   logic [REG_W-1:0] id_src [CMP_SRC_N];
   alu_fwd_e         alu_sel [ALU_SRC_N];
   logic             cmp_sel [CMP_SRC_N];

   assign ex_src[0] = ex_src_a;
   assign ex_src[1] = ex_src_b;
   assign id_src[0] = id_src_a;
   assign id_src[1] = id_src_b;

   // ALU operands: two producers per source, younger has priority
   generate
      for (genvar g = 0; g < ALU_SRC_N; g++) begin : g_alu
         logic young_hit;
         logic old_hit;

         opfwd_match #(.REG_W(REG_W), .ZERO_SINK(ZERO_SINK)) u_young (
            .en  (xm_wr_en),
            .dst (xm_dst),
            .src (ex_src[g]),
            .hit (young_hit)
         );

         opfwd_match #(.REG_W(REG_W), .ZERO_SINK(ZERO_SINK)) u_old (
            .en  (mw_wr_en),
            .dst (mw_dst),
            .src (ex_src[g]),
            .hit (old_hit)
         );

         opfwd_alu_pick u_pick (
            .young_hit (young_hit),
            .old_hit   (old_hit),
            .sel       (alu_sel[g])
         );
      end
   endgenerate

   // Decode-stage branch compare: only the execute/memory result is routed
   generate
      for (genvar g = 0; g < CMP_SRC_N; g++) begin : g_cmp
         opfwd_match #(.REG_W(REG_W), .ZERO_SINK(ZERO_SINK)) u_cmp (
            .en  (id_is_branch),
            .dst (xm_dst),
            .src (id_src[g]),
            .hit (cmp_sel[g])
         );
      end
   endgenerate

   assign alu_sel_a = alu_sel[0];
   assign alu_sel_b = alu_sel[1];
   assign cmp_sel_a = cmp_sel[0];
   assign cmp_sel_b = cmp_sel[1];

   always_comb begin
      if (!id_is_branch)
         assert_cmp_idle_R8 : assert (!cmp_sel_a && !cmp_sel_b);
      if (xm_wr_en && (xm_dst != '0) && (xm_dst == ex_src_a))
         assert_young_wins_a_R1 : assert (alu_sel_a == 2'b10);
      if (xm_wr_en && (xm_dst != '0) && (xm_dst == ex_src_b))
         assert_young_wins_b_R2 : assert (alu_sel_b == 2'b10);
      if (ZERO_SINK && (xm_dst == '0) && (mw_dst == '0))
         assert_zero_never_fwd_R4 : assert (alu_sel_a == 2'b00 && alu_sel_b == 2'b00
                                           && !cmp_sel_a && !cmp_sel_b);
   end

endmodule

// File: tb/sim_opfwd_unit.sv
`timescale 1ns/1ps
module sim_opfwd_unit;

   typedef struct packed {
      logic       xm_wr;
      logic [4:0] xm_dst;
      logic       mw_wr;
      logic [4:0] mw_dst;
      logic [4:0] exa;
      logic [4:0] exb;
      logic       br;
      logic [4:0] ida;
      logic [4:0] idb;
      logic [1:0] ea;
      logic [1:0] eb;
      logic       ec;
      logic       ed;
   } vec_t;

   localparam int VN = 18;
   localparam vec_t VECS [VN] = '{
      '{1'b0,5'd0, 1'b0,5'd0,  5'd0, 5'd0, 1'b0,5'd0, 5'd0, 2'b00,2'b00,1'b0,1'b0}, // quiet
      '{1'b1,5'd3, 1'b0,5'd0,  5'd3, 5'd4, 1'b0,5'd0, 5'd0, 2'b10,2'b00,1'b0,1'b0}, // R1
      '{1'b1,5'd4, 1'b0,5'd0,  5'd3, 5'd4, 1'b0,5'd0, 5'd0, 2'b00,2'b10,1'b0,1'b0}, // R2
      '{1'b0,5'd0, 1'b1,5'd7,  5'd7, 5'd8, 1'b0,5'd0, 5'd0, 2'b01,2'b00,1'b0,1'b0}, // R3
      '{1'b0,5'd0, 1'b1,5'd8,  5'd7, 5'd8, 1'b0,5'd0, 5'd0, 2'b00,2'b01,1'b0,1'b0}, // R3
      '{1'b1,5'd5, 1'b1,5'd5,  5'd5, 5'd5, 1'b0,5'd0, 5'd0, 2'b10,2'b10,1'b0,1'b0}, // R3 both match
      '{1'b0,5'd5, 1'b1,5'd5,  5'd5, 5'd2, 1'b0,5'd0, 5'd0, 2'b01,2'b00,1'b0,1'b0}, // R3 younger idle
      '{1'b1,5'd0, 1'b1,5'd0,  5'd0, 5'd0, 1'b0,5'd0, 5'd0, 2'b00,2'b00,1'b0,1'b0}, // R4
      '{1'b1,5'd0, 1'b1,5'd6,  5'd0, 5'd6, 1'b0,5'd0, 5'd0, 2'b00,2'b01,1'b0,1'b0}, // R4
      '{1'b1,5'd9, 1'b1,5'd10, 5'd9, 5'd10,1'b0,5'd0, 5'd0, 2'b10,2'b01,1'b0,1'b0}, // R9
      '{1'b1,5'd9, 1'b1,5'd10, 5'd10,5'd9, 1'b0,5'd0, 5'd0, 2'b01,2'b10,1'b0,1'b0}, // R9
      '{1'b0,5'd12,1'b0,5'd12, 5'd12,5'd12,1'b0,5'd0, 5'd0, 2'b00,2'b00,1'b0,1'b0}, // R5
      '{1'b1,5'd31,1'b1,5'd30, 5'd31,5'd30,1'b0,5'd0, 5'd0, 2'b10,2'b01,1'b0,1'b0}, // R9 top regs
      '{1'b0,5'd6, 1'b0,5'd0,  5'd0, 5'd0, 1'b1,5'd6, 5'd2, 2'b00,2'b00,1'b1,1'b0}, // R6
      '{1'b1,5'd2, 1'b1,5'd6,  5'd0, 5'd0, 1'b1,5'd6, 5'd2, 2'b00,2'b00,1'b0,1'b1}, // R7
      '{1'b1,5'd2, 1'b0,5'd0,  5'd0, 5'd0, 1'b0,5'd2, 5'd2, 2'b00,2'b00,1'b0,1'b0}, // R8
      '{1'b1,5'd0, 1'b0,5'd0,  5'd0, 5'd0, 1'b1,5'd0, 5'd0, 2'b00,2'b00,1'b0,1'b0}, // R4 compare
      '{1'b1,5'd11,1'b0,5'd0,  5'd0, 5'd0, 1'b1,5'd11,5'd11,2'b00,2'b00,1'b1,1'b1}  // R6 R7
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic       xm_wr_en, mw_wr_en, id_is_branch;
   logic [4:0] xm_dst, mw_dst, ex_src_a, ex_src_b, id_src_a, id_src_b;
   logic [1:0] alu_sel_a, alu_sel_b;
   logic       cmp_sel_a, cmp_sel_b;

   opfwd_unit u0 (
      .xm_wr_en     (xm_wr_en),
      .xm_dst       (xm_dst),
      .mw_wr_en     (mw_wr_en),
      .mw_dst       (mw_dst),
      .ex_src_a     (ex_src_a),
      .ex_src_b     (ex_src_b),
      .id_is_branch (id_is_branch),
      .id_src_a     (id_src_a),
      .id_src_b     (id_src_b),
      .alu_sel_a    (alu_sel_a),
      .alu_sel_b    (alu_sel_b),
      .cmp_sel_a    (cmp_sel_a),
      .cmp_sel_b    (cmp_sel_b)
   );

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      xm_wr_en = v.xm_wr; xm_dst = v.xm_dst;
      mw_wr_en = v.mw_wr; mw_dst = v.mw_dst;
      ex_src_a = v.exa;   ex_src_b = v.exb;
      id_is_branch = v.br; id_src_a = v.ida; id_src_b = v.idb;
   endtask

   initial begin
      vec_t z;
      z = '0;
      drive(z);
      repeat (3) @(posedge clk);
      @(negedge clk);
      // Reset state: quiet inputs give register file selects
      check("R5 reset alu_sel_a", alu_sel_a, 2'b00);
      check("R5 reset alu_sel_b", alu_sel_b, 2'b00);
      check("R8 reset cmp_sel_a", {1'b0, cmp_sel_a}, 2'b00);
      check("R8 reset cmp_sel_b", {1'b0, cmp_sel_b}, 2'b00);
      rst_n = 1'b1;

      for (int i = 0; i < VN; i++) begin
         @(negedge clk);
         drive(VECS[i]);
         #2;
         check($sformatf("R1,R3,R4,R5 vec%0d A", i), alu_sel_a, VECS[i].ea);
         check($sformatf("R2,R3,R4,R5 vec%0d B", i), alu_sel_b, VECS[i].eb);
         check($sformatf("R6,R8 vec%0d C", i), {1'b0, cmp_sel_a}, {1'b0, VECS[i].ec});
         check($sformatf("R7,R8 vec%0d D", i), {1'b0, cmp_sel_b}, {1'b0, VECS[i].ed});
      end

      // Sweep every destination number through both producers
      for (int r = 0; r < 32; r++) begin
         @(negedge clk);
         z = '0;
         z.xm_wr = 1'b1; z.xm_dst = 5'(r); z.exa = 5'(r);
         z.mw_wr = 1'b1; z.mw_dst = 5'(r); z.exb = 5'(r);
         z.br = 1'b1; z.ida = 5'(r); z.idb = 5'(31 - r);
         drive(z);
         #2;
         check($sformatf("R1 R4 sweep %0d", r), alu_sel_a, (r == 0) ? 2'b00 : 2'b10);
         check($sformatf("R2 R4 sweep %0d", r), alu_sel_b, (r == 0) ? 2'b00 : 2'b10);
         check($sformatf("R6 R4 sweep %0d", r), {1'b0, cmp_sel_a}, {1'b0, r != 0});
         check($sformatf("R7 sweep %0d", r), {1'b0, cmp_sel_b}, {1'b0, (r != 0) && (r == 31 - r)});
         // Older producer alone on operand B
         xm_dst = 5'((r + 1) % 32);
         #1;
         check($sformatf("R3 older sweep %0d", r), alu_sel_b,
               (r == 0) ? 2'b00 : 2'b01);
      end

      // R10: outputs follow an input change mid-cycle without a clock edge
      @(posedge clk);
      #2;
      z = '0;
      drive(z);
      #1;
      check("R10 settle low", alu_sel_a, 2'b00);
      xm_wr_en = 1'b1; xm_dst = 5'd17; ex_src_a = 5'd17;
      #1;
      check("R10 same-cycle rise", alu_sel_a, 2'b10);
      xm_wr_en = 1'b0;
      #1;
      check("R10 same-cycle fall", alu_sel_a, 2'b00);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule